// File: doc/BRIEF.md
# Multi-Latency Execution Issue Controller

This block decides, once per cycle, whether the instruction held in the register-fetch stage of an in-order load/store pipeline may move into execution. The pipeline runs fetch, decode, register fetch, execute, memory and write-back. Execution offers four units whose latencies differ. The integer unit takes 1 cycle, the floating-point adder 2, the multiplier 3 and the divider 4. The first three accept a new operation every cycle. The divider takes a new operation only once its current one has finished. Arithmetic results pass through the memory stage without work being done there. Write-back happens two cycles after a result leaves its unit.

Each cycle the controller receives a unit class, a destination register and two source registers. It answers with a stall or an issue, and it names the unit that receives the issue. For each source it gives a forwarding select. For the register file's single write port it gives the write strobe and register for the current cycle. Internally it models the datapaths only as latency counters. These are a per-register countdown to forwarding availability, a countdown for the busy divider, and a shift register that books future write-back slots together with their destination registers.

Top module: `exec_issue_ctrl`

## Requirements
- R1: A valid instruction with no hazard issues in the same cycle (issueValid high, stall low). issueUnit then echoes its unit code: 0 integer, 1 adder, 2 multiplier, 3 divider. Latency is 1, 2, 3 and 4 cycles in that order.
- R2: Suppose an instruction on a unit of latency L issues in cycle t. An instruction reading its destination stalls until cycle t+L, and it may issue in that cycle.
- R3: The forwarding select for each source is 0 for the register file. It is 1 when the youngest producer of that register writes back two cycles after the consumer issues, meaning the value comes from the memory-stage latch. It is 2 when that write-back is one cycle after issue, meaning the write-back stage. Both selects are 0 in any cycle without an issue.
- R4: After a divide issues in cycle t, another divide stalls until cycle t+4.
- R5: An instruction issued in cycle t on a unit of latency L raises wbValid in cycle t+L+2, with wbReg equal to its destination.
- R6: An instruction stalls when its write-back cycle would equal that of an instruction already in flight.
- R7: An instruction stalls when an older in-flight instruction to the same destination would write back later than it would.
- R8: stall is raised only for a valid instruction. While stalled, the instruction keeps waiting and the cycle is not an issue.
- R9: After reset no result is pending: wbValid is low and a fresh instruction issues without stalling.
- R10: The sequence divide, multiply, multiply, add, divide, subtract issues in relative cycles 0, 2, 3, 5, 7 and 8. In this sequence the subtract overwrites a source of the second divide, and this causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Register-fetch stage holds an instruction |
| instUnit | input | 2 | Unit code of that instruction |
| instDst | input | 5 | Destination register |
| instSrcA | input | 5 | First source register |
| instSrcB | input | 5 | Second source register |
| stall | output | 1 | Instruction must wait in register fetch |
| issueValid | output | 1 | Instruction enters execution next cycle |
| issueUnit | output | 2 | Unit receiving the issue (0 when idle) |
| fwdSelA | output | 2 | Operand source for first source register |
| fwdSelB | output | 2 | Operand source for second source register |
| wbValid | output | 1 | Register file written this cycle |
| wbReg | output | 5 | Register written this cycle |

## Verification
A corrupted readiness countdown or a lost slot booking shows up at the ports within the latency window of the unit involved. At most six cycles later the controller either issues early, which appears as a wrong forwarding select or a second write-back in one cycle, or it stalls when the reference model expects an issue. A slot booked in the wrong place moves wbValid and wbReg away from cycle t+L+2. The next write-back therefore exposes the error. The bench compares stall, issue, unit, both forwarding selects and the write-back outputs on every cycle against a behavioural model. It runs directed sequences and a dependency-heavy random stream over eight registers.

// File: rtl/issue_ctrl_pkg.sv
package issue_ctrl_pkg;

  typedef enum logic [1:0] {
    UNIT_INT  = 2'd0,
    UNIT_FADD = 2'd1,
    UNIT_MUL  = 2'd2,
    UNIT_DIV  = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_e;

  // strobes from the issue control to the tracking datapath
  typedef struct packed {
    logic issue;
    logic divStart;
  } issue_strobe_t;

endpackage

// File: rtl/issue_hazard_ctrl.sv
module issue_hazard_ctrl
  import issue_ctrl_pkg::*;
(
  input  logic          instValid,
  input  unit_e         instUnit,
  input  logic          rawHit,
  input  logic          wawHit,
  input  logic          wbHit,
  input  logic          divBusy,
  output logic          stall,
  output issue_strobe_t strobe
);

  logic divBlock;
  logic anyHazard;

  assign divBlock  = (instUnit == UNIT_DIV) && divBusy;
  assign anyHazard = rawHit || wawHit || wbHit || divBlock;

  always_comb begin
    stall           = instValid && anyHazard;
    strobe.issue    = instValid && !anyHazard;
    strobe.divStart = instValid && !anyHazard && (instUnit == UNIT_DIV);
  end

endmodule

// File: rtl/issue_track_dp.sv
module issue_track_dp
  import issue_ctrl_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LAT_INT  = 1,
  parameter int LAT_FADD = 2,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  issue_strobe_t    strobe,
  input  unit_e            instUnit,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrcA,
  input  logic [REG_W-1:0] instSrcB,
  output logic             rawHit,
  output logic             wawHit,
  output logic             wbHit,
  output logic             divBusy,
  output fwd_e             fwdSelA,
  output fwd_e             fwdSelB,
  output logic             wbValid,
  output logic [REG_W-1:0] wbReg
);

  localparam int MAX_AB   = (LAT_INT > LAT_FADD) ? LAT_INT : LAT_FADD;
  localparam int MAX_CD   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int MAX_LAT  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W    = $clog2(MAX_LAT);
  // slot k books the write-back k cycles from now; issue books MAX_LAT+2 at most
  localparam int WB_DEPTH = MAX_LAT + 3;
  localparam int IDX_W    = $clog2(WB_DEPTH);

  logic [IDX_W-1:0] curLat;
  logic [CNT_W-1:0] readyCnt [NUM_REGS];
  logic [CNT_W-1:0] divCnt;
  logic             slotVld  [WB_DEPTH];
  logic [REG_W-1:0] slotDst  [WB_DEPTH];

  always_comb begin
    unique case (instUnit)
      UNIT_INT:  curLat = IDX_W'(LAT_INT);
      UNIT_FADD: curLat = IDX_W'(LAT_FADD);
      UNIT_MUL:  curLat = IDX_W'(LAT_MUL);
      default:   curLat = IDX_W'(LAT_DIV);
    endcase
  end

  // countdown per register until its pending result can be forwarded
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ready
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        readyCnt[r] <= '0;
      end else if (strobe.issue && (instDst == REG_W'(r))) begin
        readyCnt[r] <= CNT_W'(int'(curLat) - 1);
      end else if (readyCnt[r] != '0) begin
        readyCnt[r] <= readyCnt[r] - CNT_W'(1);
      end
    end
  end

  // non-pipelined divider occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.divStart) begin
      divCnt <= CNT_W'(LAT_DIV - 1);
    end else if (divCnt != '0) begin
      divCnt <= divCnt - CNT_W'(1);
    end
  end

  // write-back slot reservation shift register
  for (genvar k = 0; k < WB_DEPTH; k++) begin : g_slot
    logic bookHere;
    assign bookHere = strobe.issue && ((int'(curLat) + 1) == k);
    if (k < WB_DEPTH - 1) begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotVld[k] <= 1'b0;
          slotDst[k] <= '0;
        end else if (bookHere) begin
          slotVld[k] <= 1'b1;
          slotDst[k] <= instDst;
        end else begin
          slotVld[k] <= slotVld[k+1];
          slotDst[k] <= slotDst[k+1];
        end
      end
    end else begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotVld[k] <= 1'b0;
          slotDst[k] <= '0;
        end else if (bookHere) begin
          slotVld[k] <= 1'b1;
          slotDst[k] <= instDst;
        end else begin
          slotVld[k] <= 1'b0;
          slotDst[k] <= '0;
        end
      end
    end
  end

  always_comb begin
    rawHit = (readyCnt[instSrcA] != '0) || (readyCnt[instSrcB] != '0);
    wbHit  = 1'b0;
    wawHit = 1'b0;
    for (int k = 0; k < WB_DEPTH; k++) begin
      if (k == int'(curLat) + 2) begin
        wbHit = wbHit || slotVld[k];
      end
      if ((k > int'(curLat) + 2) && slotVld[k] && (slotDst[k] == instDst)) begin
        wawHit = 1'b1;
      end
    end
  end

  assign divBusy = (divCnt != '0);

  always_comb begin
    fwdSelA = FWD_RF;
    fwdSelB = FWD_RF;
    if (strobe.issue) begin
      if (slotVld[2] && (slotDst[2] == instSrcA))      fwdSelA = FWD_MEM;
      else if (slotVld[1] && (slotDst[1] == instSrcA)) fwdSelA = FWD_WB;
      if (slotVld[2] && (slotDst[2] == instSrcB))      fwdSelB = FWD_MEM;
      else if (slotVld[1] && (slotDst[1] == instSrcB)) fwdSelB = FWD_WB;
    end
  end

  assign wbValid = slotVld[0];
  assign wbReg   = slotDst[0];

endmodule

// File: rtl/exec_issue_ctrl.sv
module exec_issue_ctrl
  import issue_ctrl_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LAT_INT  = 1,
  parameter int LAT_FADD = 2,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [1:0]       instUnit,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrcA,
  input  logic [REG_W-1:0] instSrcB,
  output logic             stall,
  output logic             issueValid,
  output logic [1:0]       issueUnit,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             wbValid,
  output logic [REG_W-1:0] wbReg
);

  unit_e         unitIn;
  issue_strobe_t strobe;
  logic          rawHit;
  logic          wawHit;
  logic          wbHit;
  logic          divBusy;
  fwd_e          selA;
  fwd_e          selB;

  assign unitIn = unit_e'(instUnit);

  issue_hazard_ctrl u_ctrl (
    .instValid (instValid),
    .instUnit  (unitIn),
    .rawHit    (rawHit),
    .wawHit    (wawHit),
    .wbHit     (wbHit),
    .divBusy   (divBusy),
    .stall     (stall),
    .strobe    (strobe)
  );

  issue_track_dp #(
    .NUM_REGS (NUM_REGS),
    .LAT_INT  (LAT_INT),
    .LAT_FADD (LAT_FADD),
    .LAT_MUL  (LAT_MUL),
    .LAT_DIV  (LAT_DIV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .instUnit (unitIn),
    .instDst  (instDst),
    .instSrcA (instSrcA),
    .instSrcB (instSrcB),
    .rawHit   (rawHit),
    .wawHit   (wawHit),
    .wbHit    (wbHit),
    .divBusy  (divBusy),
    .fwdSelA  (selA),
    .fwdSelB  (selB),
    .wbValid  (wbValid),
    .wbReg    (wbReg)
  );

  assign issueValid = strobe.issue;
  assign issueUnit  = strobe.issue ? instUnit : 2'b00;
  assign fwdSelA    = selA;
  assign fwdSelB    = selB;

endmodule

// File: rtl/exec_issue_ctrl_chk.sv
module exec_issue_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       instValid,
  input logic       stall,
  input logic       issueValid,
  input logic [1:0] issueUnit,
  input logic [1:0] fwdSelA,
  input logic [1:0] fwdSelB,
  input logic       wbValid
);

  // R8
  stall_needs_inst_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> instValid);

  // R1
  issue_not_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (instValid && !stall));

  // R4
  div_gap_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd3) |=> !(issueValid && issueUnit == 2'd3));

  // R4
  div_gap_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd3) |-> ##2 !(issueValid && issueUnit == 2'd3));

  // R4
  div_gap_three_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd3) |-> ##3 !(issueValid && issueUnit == 2'd3));

  // R5
  int_wb_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd0) |-> ##3 wbValid);

  // R5
  div_wb_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd3) |-> ##6 wbValid);

  // R6
  wb_port_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueUnit == 2'd2) |=> !(issueValid && issueUnit == 2'd1));

  // R3
  fwd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((fwdSelA != 2'd0) || (fwdSelB != 2'd0)) |-> issueValid);

endmodule

bind exec_issue_ctrl exec_issue_ctrl_chk u_chk (.*);

// File: tb/exec_issue_ctrl_bench.sv
`timescale 1ns/1ps
module exec_issue_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] instUnit = 2'd0;
  logic [4:0] instDst = 5'd0;
  logic [4:0] instSrcA = 5'd0;
  logic [4:0] instSrcB = 5'd0;
  logic       stall;
  logic       issueValid;
  logic [1:0] issueUnit;
  logic [1:0] fwdSelA;
  logic [1:0] fwdSelB;
  logic       wbValid;
  logic [4:0] wbReg;

  always #10 clk = ~clk;

  exec_issue_ctrl u_exec_issue_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instUnit(instUnit),
    .instDst(instDst), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .stall(stall), .issueValid(issueValid), .issueUnit(issueUnit),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .wbValid(wbValid), .wbReg(wbReg)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int now = 0;
  int readyAt [32];
  int lastWb  [32];
  int divFree = -100;
  int wbAt [int];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, now, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one cycle: drive, compare with the model, advance
  task automatic step(input bit v, input int u, input int d, input int a, input int b,
                      output bit issued, output int fa, output int fb);
    int lat;
    bit rawE, divE, wbE, wawE, expStall, expIssue;
    int expA, expB;
    string why;
    instValid = v; instUnit = 2'(u); instDst = 5'(d); instSrcA = 5'(a); instSrcB = 5'(b);
    #1;
    lat  = u + 1;
    rawE = (now < readyAt[a]) || (now < readyAt[b]);
    divE = (u == 3) && (now < divFree);
    wbE  = wbAt.exists(now + lat + 2);
    wawE = lastWb[d] > now + lat + 2;
    expStall = v && (rawE || divE || wbE || wawE);
    expIssue = v && !expStall;
    why = wbE ? "R6" : wawE ? "R7" : divE ? "R4" : rawE ? "R2" : v ? "R1" : "R8";
    expA = !expIssue ? 0 : (lastWb[a] == now + 2) ? 1 : (lastWb[a] == now + 1) ? 2 : 0;
    expB = !expIssue ? 0 : (lastWb[b] == now + 2) ? 1 : (lastWb[b] == now + 1) ? 2 : 0;
    chk(stall == expStall, why, "stall", int'(stall), int'(expStall));
    chk(issueValid == expIssue, why, "issueValid", int'(issueValid), int'(expIssue));
    chk(int'(issueUnit) == (expIssue ? u : 0), "R1", "issueUnit", int'(issueUnit), expIssue ? u : 0);
    chk(int'(fwdSelA) == expA, "R3", "fwdSelA", int'(fwdSelA), expA);
    chk(int'(fwdSelB) == expB, "R3", "fwdSelB", int'(fwdSelB), expB);
    chk(wbValid == wbAt.exists(now), "R5", "wbValid", int'(wbValid), int'(wbAt.exists(now)));
    if (wbAt.exists(now)) begin
      chk(int'(wbReg) == wbAt[now], "R5", "wbReg", int'(wbReg), wbAt[now]);
      wbAt.delete(now);
    end
    if (expIssue) begin
      readyAt[d] = now + lat;
      lastWb[d]  = now + lat + 2;
      wbAt[now + lat + 2] = d;
      if (u == 3) divFree = now + 4;
    end
    issued = issueValid;
    fa = int'(fwdSelA);
    fb = int'(fwdSelB);
    @(negedge clk);
    now++;
  endtask

  task automatic idle(input int n);
    bit i; int fa, fb;
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, i, fa, fb);
  endtask

  // issues one instruction, holding it through stalls; returns relative issue cycle
  task automatic runOne(input int u, input int d, input int a, input int b,
                        input int base, output int at, output int fa, output int fb);
    bit i;
    at = -1;
    for (int k = 0; k < 20 && at < 0; k++) begin
      step(1, u, d, a, b, i, fa, fb);
      if (i) at = now - 1 - base;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", now);
    finishRun();
  end

  initial begin : main
    int seqU [6] = '{3, 2, 2, 1, 3, 1};
    int seqD [6] = '{0, 6, 12, 4, 8, 4};
    int seqA [6] = '{2, 2, 8, 8, 4, 4};
    int seqB [6] = '{4, 4, 10, 10, 6, 2};
    int seqT [6] = '{0, 2, 3, 5, 7, 8};
    int at, fa, fb, base;
    for (int r = 0; r < 32; r++) begin readyAt[r] = -100; lastWb[r] = -100; end

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(wbValid == 1'b0, "R9", "wbValid in reset", int'(wbValid), 0);
    chk(stall == 1'b0, "R9", "stall in reset", int'(stall), 0);
    rstN = 1'b1;
    now = 0;
    // R9: first instruction after reset issues at once
    base = now;
    runOne(0, 1, 2, 3, base, at, fa, fb);
    chk(at == 0, "R9", "first issue cycle", at, 0);
    idle(10);

    // R10: reference sequence schedule, WAR by the subtract is harmless
    base = now;
    for (int i = 0; i < 6; i++) begin
      runOne(seqU[i], seqD[i], seqA[i], seqB[i], base, at, fa, fb);
      chk(at == seqT[i], "R10", "issue cycle", at, seqT[i]);
      if (i == 4) begin
        chk(fa == 1, "R3", "divide srcA from memory latch", fa, 1);
        chk(fb == 0, "R3", "divide srcB from file", fb, 0);
      end
      if (i == 5) chk(fa == 2, "R3", "subtract srcA from write-back", fa, 2);
    end
    idle(12);

    // R7: short op behind long op to the same register
    base = now;
    runOne(3, 1, 2, 3, base, at, fa, fb);
    runOne(0, 1, 2, 3, base, at, fa, fb);
    chk(at == 4, "R7", "waw release cycle", at, 4);
    idle(12);

    // R4: back-to-back independent divides
    base = now;
    runOne(3, 10, 11, 12, base, at, fa, fb);
    runOne(3, 13, 14, 15, base, at, fa, fb);
    chk(at == 4, "R4", "second divide cycle", at, 4);
    idle(12);

    // R2: multiply then dependent integer op
    base = now;
    runOne(2, 20, 21, 22, base, at, fa, fb);
    runOne(0, 23, 20, 21, base, at, fa, fb);
    chk(at == 3, "R2", "dependent issue cycle", at, 3);
    chk(fa == 1, "R3", "dependent srcA select", fa, 1);
    idle(12);

    // R6: multiply then add booking the same write-back cycle
    base = now;
    runOne(2, 24, 25, 26, base, at, fa, fb);
    runOne(1, 27, 28, 29, base, at, fa, fb);
    chk(at == 2, "R6", "add issue after clash", at, 2);
    idle(12);

    // random dependency-heavy stream, instruction held while stalled
    begin
      bit have = 0, v = 0, iss;
      int u = 0, d = 0, a = 0, b = 0;
      for (int n = 0; n < 600; n++) begin
        if (!have) begin
          v = ($urandom % 5) != 0;
          u = $urandom % 4; d = $urandom % 8; a = $urandom % 8; b = $urandom % 8;
          have = v;
        end
        step(v, u, d, a, b, iss, fa, fb);
        if (iss) have = 0;
      end
    end
    idle(12);
    finishRun();
  end

endmodule